// File: doc/BRIEF.md
# Decimal Field Arithmetic Unit

This unit adds or subtracts over a chosen slice of a 56-bit register made of fourteen 4-bit digits. The caller supplies the destination operand, a second operand, and a field code. The second operand is either another register or a single 4-bit constant. The field code picks either a fixed slice or a range set by a 4-bit digit pointer. The unit walks the field one digit per clock, starting at the least significant selected digit. It propagates a decimal carry, or a binary carry in hex mode. Each result digit goes back into the destination copy, and the final carry or borrow is reported at the end.

Digit layout: the exponent is in digits 0–1, the exponent sign in digit 2, the mantissa in digits 3–12 and the mantissa sign in digit 13. A sign digit of 0 means positive and 9 means negative. The unit itself treats sign digits like any other digit. A typical use is a floating-point sequencer that issues one field operation at a time and waits for the done pulse.

Top module: `bcd_field_alu`

## Requirements
- R1: After reset, busy_o and done_o are 0, res_o is all zeros and carry_o is 0.
- R2: fld_i selects the digit range (low..high). 0 = pointer digit p..p, 1 = digits 0..p, 2 = digits 0..1, 3 = digits 0..2, 4 = digits 3..12, 5 = digits 3..13, 6 = digits 0..13, 7 = digit 13 only. Here p is ptr_i after R3.
- R3: A ptr_i value above 13 is treated as 13.
- R4: In decimal mode (hex_i=0) an add forms x+y+c per digit. If the sum is 10 or more, the digit becomes the sum minus 10 and a carry of 1 goes to the next digit. Carry into the first digit is 0. carry_o is the carry out of the top digit.
- R5: Subtract (sub_i=1) computes destination minus operand as an add of the nines' complement (9−y, taken mod 16) with carry-in 1. carry_o is 1 exactly when the top digit produced no carry, meaning a borrow occurred.
- R6: With hex_i=1 the radix is 16. Add carries when the sum reaches 16. Subtract uses the fifteens' complement (15−y) with carry-in 1.
- R7: res_o equals a_i, as latched at start, in every digit outside the selected field.
- R8: Take a start edge that sees start_i=1 while idle, with an n-digit field. busy_o is 1 for the next n cycles. On the n-th following edge, busy_o falls and done_o rises for exactly one cycle. At that point res_o and carry_o hold the result.
- R9: start_i is ignored while busy_o is 1. The running operation finishes with its original operands.
- R10: With imm_en_i=1 the second operand is imm_i at the lowest selected digit and 0 at every other digit, and b_i is ignored.
- R11: After done, res_o and carry_o keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| hex_i | input | 1 | 1 = binary radix-16 digits, 0 = decimal |
| imm_en_i | input | 1 | Use imm_i in place of b_i |
| imm_i | input | 4 | Constant digit operand |
| fld_i | input | 3 | Field code (R2) |
| ptr_i | input | 4 | Digit pointer |
| a_i | input | 56 | Destination operand |
| b_i | input | 56 | Second register operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 56 | Destination register after the operation |
| carry_o | output | 1 | Final carry (add) or borrow (subtract) |

## Verification
Every operation lasts a number of clocks equal to the width of its field. For an n-digit field, busy_o must read 1 at the sample points after the start edge and after each of the next n−1 edges. done_o, res_o and carry_o are due right after the n-th edge, and done_o must read 0 again one cycle later. The bench drives inputs on falling edges and keeps a behavioural digit-by-digit model that also predicts n. It compares busy, done, result and carry at every falling edge of the operation window and at the cycle after it. Corner cases include pointer values 14 and 15, a mid-operation start, all-nines overflow, borrow, and hex wrap.

// File: rtl/bcd_field_pkg.sv
package bcd_field_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned NIBS  = 14;
  localparam int unsigned REG_W = NIB_W * NIBS;
  localparam int unsigned IDX_W = 4;

  localparam int unsigned EXP_LO  = 0;
  localparam int unsigned EXP_HI  = 1;
  localparam int unsigned EXP_SGN = 2;
  localparam int unsigned MAN_LO  = 3;
  localparam int unsigned MAN_HI  = 12;
  localparam int unsigned MAN_SGN = 13;

  typedef enum logic [2:0] {
    FLD_PTR  = 3'd0,
    FLD_UPTO = 3'd1,
    FLD_EXP  = 3'd2,
    FLD_EXPS = 3'd3,
    FLD_MAN  = 3'd4,
    FLD_MANS = 3'd5,
    FLD_WORD = 3'd6,
    FLD_SIGN = 3'd7
  } fld_e;
endpackage

// File: rtl/bcd_field_decode.sv
module bcd_field_decode
  import bcd_field_pkg::*;
(
  input  fld_e             fld_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] lo_o,
  output logic [IDX_W-1:0] hi_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NIBS - 1);

  logic [IDX_W-1:0] p_c;

  always_comb begin
    p_c  = (ptr_i > TOP) ? TOP : ptr_i;
    lo_o = '0;
    hi_o = TOP;
    unique case (fld_i)
      FLD_PTR:  begin lo_o = p_c;                 hi_o = p_c;                 end
      FLD_UPTO: begin lo_o = '0;                  hi_o = p_c;                 end
      FLD_EXP:  begin lo_o = IDX_W'(EXP_LO);      hi_o = IDX_W'(EXP_HI);      end
      FLD_EXPS: begin lo_o = IDX_W'(EXP_LO);      hi_o = IDX_W'(EXP_SGN);     end
      FLD_MAN:  begin lo_o = IDX_W'(MAN_LO);      hi_o = IDX_W'(MAN_HI);      end
      FLD_MANS: begin lo_o = IDX_W'(MAN_LO);      hi_o = IDX_W'(MAN_SGN);     end
      FLD_WORD: begin lo_o = '0;                  hi_o = TOP;                 end
      FLD_SIGN: begin lo_o = IDX_W'(MAN_SGN);     hi_o = IDX_W'(MAN_SGN);     end
      default:  begin lo_o = '0;                  hi_o = TOP;                 end
    endcase
  end

  // R3: range never leaves the register, never inverted
  always_comb begin
    a_r3_range_legal: assert (hi_o <= TOP && lo_o <= hi_o)
      else $error("field range out of bounds");
  end
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_field_pkg::*;
(
  input  logic [NIB_W-1:0] x_i,
  input  logic [NIB_W-1:0] y_i,
  input  logic             cin_i,
  input  logic             sub_i,
  input  logic             hex_i,
  output logic [NIB_W-1:0] sum_o,
  output logic             cout_o
);
  localparam logic [NIB_W:0] RAD_DEC = (NIB_W+1)'(10);
  localparam logic [NIB_W:0] RAD_HEX = (NIB_W+1)'(16);

  logic [NIB_W-1:0] yc;
  logic [NIB_W:0]   raw;
  logic [NIB_W:0]   radix;
  logic [NIB_W:0]   wrapped;

  always_comb begin
    yc = y_i;
    if (sub_i) yc = hex_i ? ~y_i : (NIB_W'(9) - y_i);
    raw     = {1'b0, x_i} + {1'b0, yc} + {{NIB_W{1'b0}}, cin_i};
    radix   = hex_i ? RAD_HEX : RAD_DEC;
    cout_o  = (raw >= radix);
    wrapped = raw - radix;
    sum_o   = cout_o ? wrapped[NIB_W-1:0] : raw[NIB_W-1:0];
  end

  // R4: valid decimal digits in give a valid decimal digit out
  always_comb begin
    if (!hex_i && x_i <= NIB_W'(9) && y_i <= NIB_W'(9))
      a_r4_decimal_digit: assert (sum_o <= NIB_W'(9))
        else $error("decimal digit out of range");
  end
endmodule

// File: rtl/bcd_field_alu.sv
module bcd_field_alu
  import bcd_field_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic             hex_i,
  input  logic             imm_en_i,
  input  logic [3:0]       imm_i,
  input  logic [2:0]       fld_i,
  input  logic [3:0]       ptr_i,
  input  logic [55:0]      a_i,
  input  logic [55:0]      b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [55:0]      res_o,
  output logic             carry_o
);
  localparam logic [REG_W-1:0] NIB_MASK = REG_W'({NIB_W{1'b1}});

  logic             busy_q, done_q, cy_q, sub_q, hex_q;
  logic [IDX_W-1:0] idx_q, hi_q, lo_c, hi_c;
  logic [REG_W-1:0] acc_q, opb_q, opb_c;
  logic [NIB_W-1:0] x_d, y_d, sum_d;
  logic             cout_d;

  bcd_field_decode u_dec (
    .fld_i (fld_e'(fld_i)),
    .ptr_i (ptr_i),
    .lo_o  (lo_c),
    .hi_o  (hi_c)
  );

  // constant operand sits at the lowest selected digit
  always_comb begin
    opb_c = imm_en_i ? (REG_W'(imm_i) << (NIB_W * lo_c)) : b_i;
    x_d   = acc_q[idx_q*NIB_W +: NIB_W];
    y_d   = opb_q[idx_q*NIB_W +: NIB_W];
  end

  bcd_digit_add u_add (
    .x_i    (x_d),
    .y_i    (y_d),
    .cin_i  (cy_q),
    .sub_i  (sub_q),
    .hex_i  (hex_q),
    .sum_o  (sum_d),
    .cout_o (cout_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cy_q   <= 1'b0;
      sub_q  <= 1'b0;
      hex_q  <= 1'b0;
      idx_q  <= '0;
      hi_q   <= '0;
      acc_q  <= '0;
      opb_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          acc_q  <= a_i;
          opb_q  <= opb_c;
          idx_q  <= lo_c;
          hi_q   <= hi_c;
          cy_q   <= sub_i;
          sub_q  <= sub_i;
          hex_q  <= hex_i;
        end
      end else begin
        acc_q[idx_q*NIB_W +: NIB_W] <= sum_d;
        cy_q <= cout_d;
        if (idx_q == hi_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign res_o   = acc_q;
  assign carry_o = sub_q ? ~cy_q : cy_q;

  a_r8_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q <= hi_q);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && $past(busy_q));

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> hi_q == $past(hi_q));

  a_r7_one_digit_per_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ((acc_q ^ $past(acc_q)) & ~(NIB_MASK << (NIB_W * $past(idx_q)))) == '0);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start_i |=> $stable(acc_q) && $stable(carry_o));
endmodule

// File: tb/bcd_field_alu_tb.sv
module bcd_field_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, sub_i = 1'b0, hex_i = 1'b0, imm_en_i = 1'b0;
  logic [3:0]  imm_i = '0;
  logic [2:0]  fld_i = '0;
  logic [3:0]  ptr_i = '0;
  logic [55:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o, carry_o;
  logic [55:0] res_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bcd_field_alu dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sub_i(sub_i), .hex_i(hex_i),
    .imm_en_i(imm_en_i), .imm_i(imm_i), .fld_i(fld_i), .ptr_i(ptr_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .res_o(res_o),
    .carry_o(carry_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model
  task automatic model(input bit sub, input bit hex, input bit imm_en, input int imm,
                       input int fld, input int ptr, input logic [55:0] a,
                       input logic [55:0] b, output logic [55:0] res,
                       output bit cy, output int n);
    int p, lo, hi, c, x, y, s, rad;
    int dg[14];
    p = (ptr > 13) ? 13 : ptr;
    case (fld)
      0: begin lo = p;  hi = p;  end
      1: begin lo = 0;  hi = p;  end
      2: begin lo = 0;  hi = 1;  end
      3: begin lo = 0;  hi = 2;  end
      4: begin lo = 3;  hi = 12; end
      5: begin lo = 3;  hi = 13; end
      6: begin lo = 0;  hi = 13; end
      default: begin lo = 13; hi = 13; end
    endcase
    for (int i = 0; i < 14; i++) dg[i] = int'(b[i*4 +: 4]);
    if (imm_en) begin
      for (int i = 0; i < 14; i++) dg[i] = 0;
      dg[lo] = imm;
    end
    res = a;
    c = sub ? 1 : 0;
    rad = hex ? 16 : 10;
    for (int i = lo; i <= hi; i++) begin
      x = int'(a[i*4 +: 4]);
      y = dg[i];
      if (sub) y = hex ? (15 - y) : ((9 - y) & 15);
      s = x + y + c;
      if (s >= rad) begin c = 1; s = s - rad; end
      else c = 0;
      res[i*4 +: 4] = 4'(s & 15);
    end
    cy = sub ? (c == 0) : (c == 1);
    n = hi - lo + 1;
  endtask

  task automatic run(input string tag, input bit sub, input bit hex, input bit imm_en,
                     input int imm, input int fld, input int ptr,
                     input logic [55:0] a, input logic [55:0] b, input bit poke);
    logic [55:0] er;
    bit ec;
    int n;
    model(sub, hex, imm_en, imm, fld, ptr, a, b, er, ec, n);
    @(negedge clk);
    start_i = 1'b1; sub_i = sub; hex_i = hex; imm_en_i = imm_en; imm_i = 4'(imm);
    fld_i = 3'(fld); ptr_i = 4'(ptr); a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < n; j++) begin
      chk({tag, " R8 busy"}, 64'(busy_o), 64'd1);
      chk({tag, " R8 done early"}, 64'(done_o), 64'd0);
      if (poke && j == 0) begin
        // R9: a second start mid-operation with other operands
        start_i = 1'b1; a_i = 56'h12345678901234; b_i = 56'h55555555555555;
        fld_i = 3'd2; sub_i = ~sub;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk({tag, " R8 done"}, 64'(done_o), 64'd1);
    chk({tag, " R8 busy end"}, 64'(busy_o), 64'd0);
    chk({tag, " result"}, 64'(res_o), 64'(er));
    chk({tag, " carry"}, 64'(carry_o), 64'(ec));
    @(negedge clk);
    chk({tag, " R8 done pulse"}, 64'(done_o), 64'd0);
    chk({tag, " R11 hold result"}, 64'(res_o), 64'(er));
    chk({tag, " R11 hold carry"}, 64'(carry_o), 64'(ec));
  endtask

  initial begin
    #4_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", 64'(busy_o), 64'd0);
    chk("R1 done reset", 64'(done_o), 64'd0);
    chk("R1 res reset", 64'(res_o), 64'd0);
    chk("R1 carry reset", 64'(carry_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    run("R4 word overflow", 0, 0, 0, 0, 6, 0, 56'h99999999999999, 56'h00000000000001, 0);
    run("R4 word add", 0, 0, 0, 0, 6, 0, 56'h01234567890123, 56'h09876543210987, 0);
    run("R2 R7 exp add", 0, 0, 0, 0, 2, 0, 56'h31415926535847, 56'h00000000000085, 0);
    run("R5 mantissa borrow", 1, 0, 0, 0, 4, 0, 56'h01000000000002, 56'h02000000000001, 0);
    run("R5 mantissa sub", 1, 0, 0, 0, 4, 0, 56'h05000000000000, 56'h01999999999999, 0);
    run("R2 exp+sign", 0, 0, 0, 0, 3, 0, 56'h11111111111950, 56'h22222222222060, 0);
    run("R2 mant+sign", 0, 0, 0, 0, 5, 0, 56'h04999999999912, 56'h05000000000134, 0);
    run("R2 sign digit", 0, 0, 0, 0, 7, 0, 56'h01234567890123, 56'h90000000000000, 0);
    run("R2 R7 pointer digit", 0, 0, 0, 0, 0, 5, 56'h77777777777777, 56'h00000000900000, 0);
    run("R2 up to pointer", 1, 0, 0, 0, 1, 3, 56'h66666666661000, 56'h00000000000001, 0);
    run("R3 ptr 15 upto", 0, 0, 0, 0, 1, 15, 56'h99999999999999, 56'h00000000000001, 0);
    run("R3 ptr 14 digit", 0, 0, 0, 0, 0, 14, 56'h91234567890123, 56'h90000000000000, 0);
    run("R6 hex add", 0, 1, 0, 0, 6, 0, 56'h0000000000FFFF, 56'h00000000000001, 0);
    run("R6 hex sub", 1, 1, 0, 0, 2, 0, 56'hABCDEF01234510, 56'h000000000000A1, 0);
    run("R10 imm inc mant", 0, 0, 1, 1, 4, 0, 56'h00999999999942, 56'h77777777777777, 0);
    run("R10 imm dec exp", 1, 0, 1, 1, 2, 0, 56'h12345678901200, 56'h11111111111111, 0);
    run("R9 start ignored", 0, 0, 0, 0, 6, 0, 56'h12312312312312, 56'h45645645645645, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule